// File: doc/BRIEF.md
# Panel Timing Generator

This block produces the line sync, frame sync, data-enable and colour bus for a parallel RGB panel. Software sets it up through a write-only register port. Horizontal positions are pixel-clock counts within a line. Vertical positions are pixel-clock counts from the start of the frame, so vertical edges may land at any pixel of a line. A separate skew value moves the line-sync pulse later within the line. Software adds the same skew to its vertical window values so that data-enable stays aligned with the moved sync.

A sub-window may be enabled inside the display area. Only sub-window pixels take data from the input stream, which uses a valid/ready handshake. Display pixels outside the sub-window show a border colour. When the stream has no data for an active pixel, an underflow colour is shown in its place. With recovery enabled, one missing pixel makes the block show the underflow colour for the rest of the frame without taking input, and it resynchronises at the next frame start. Every timing register is copied into a working set only at a frame boundary, or at any time while the generator is stopped, so a frame never mixes two setups. The sync, data-enable and colour outputs are registered, so each reflects the counter position one clock earlier. The ready output reflects the current position.

Top module: `panel_timing_gen`

## Requirements
- R1: While reset is applied, and afterwards until the generator is enabled, `lcd_hsync`, `lcd_vsync`, `lcd_de`, `lcd_rgb` and `pix_ready` are all 0.
- R2: The register at byte offset 0x04 holds the line period in bits [27:16] and the sync width in bits [11:0]. The register at 0x30 holds the skew in bits [11:0]. The line position counts from 0 to period−1. Raw line sync is high while skew ≤ position < skew + width.
- R3: The register at 0x08 holds the frame period in pixel clocks and the register at 0x0C holds the frame-sync width, both in bits [23:0]. The frame position counts from 0 to period−1, and the line position also restarts when the frame position wraps. Raw frame sync is high while the frame position is below the width.
- R4: The register at 0x10 holds the display end pixel in bits [27:16] and the start pixel in bits [11:0]. The registers at 0x14 and 0x18 hold the first and last display frame positions. Raw data-enable is high exactly when both positions lie inside these inclusive ranges.
- R5: The register at 0x1C holds an enable in bit 31, the sub-window end pixel in [27:16] and the start pixel in [11:0]. The register at 0x20 holds an enable in bit 31 and the first frame position in [23:0], and the register at 0x24 holds the last frame position. When an enable is clear, the sub-window matches the display window in that direction.
- R6: A display pixel outside the sub-window shows the border colour held in bits [23:0] of the register at 0x28. Outside the display area the colour bus is 0.
- R7: With recovery off, an active pixel shows the input data when `pix_valid` is high, and shows the underflow colour (bits [23:0] of the register at 0x2C) otherwise. The next pixel uses input data again.
- R8: With recovery on (bit 31 of the register at 0x2C), an active pixel without valid input sets a lock. While the lock is set, `pix_ready` is low and every active pixel shows the underflow colour. The lock clears when the frame position wraps.
- R9: `pix_ready` is high exactly on active, unlocked positions, and one pixel is taken per handshake.
- R10: In the register at 0x38, bit 0 inverts line sync, bit 1 inverts frame sync and bit 2 inverts data-enable, including while the generator is stopped.
- R11: Writes to timing and colour registers take effect from the first position of the next frame. A write that lands on the last clock of a frame waits one more frame.
- R12: Bit 0 of the register at 0x00 runs the generator. Clearing it holds both counters at 0 and drops all raw outputs. Setting it again starts a new frame at position 0 with the setup current at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Input pixel present |
| pix_data | input | 24 | Input pixel colour |
| pix_ready | output | 1 | Input pixel taken this clock |
| lcd_hsync | output | 1 | Line sync after polarity |
| lcd_vsync | output | 1 | Frame sync after polarity |
| lcd_de | output | 1 | Data enable after polarity |
| lcd_rgb | output | 24 | Panel colour |

## Verification
The hardest case to reach is the recovery lock meeting the frame wrap. An underflow must set the lock mid-frame, the rest of that frame must show only the underflow colour, and the next frame must start taking input again on the exact first active pixel. A second hard case is a register write landing near the wrap clock. The stimulus gates `pix_valid` with patterns whose periods share no factor with the line length, so dropouts fall on varied pixels across many frames. Setup writes are issued at whatever frame position the sequence happens to reach. A cycle-accurate model in the bench tracks its own working copy of the registers and compares every output on every clock.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int HW = 12;          // line position width
    localparam int FW = 24;          // frame position width
    localparam int PW = 24;          // colour width
    localparam int AW = 6;           // register byte address width
    localparam int IW = AW - 2;      // register index width

    localparam logic [IW-1:0] IDX_RUN    = 4'd0;
    localparam logic [IW-1:0] IDX_LINE   = 4'd1;
    localparam logic [IW-1:0] IDX_FRAME  = 4'd2;
    localparam logic [IW-1:0] IDX_FSYNC  = 4'd3;
    localparam logic [IW-1:0] IDX_DISP_H = 4'd4;
    localparam logic [IW-1:0] IDX_DISP_VS = 4'd5;
    localparam logic [IW-1:0] IDX_DISP_VE = 4'd6;
    localparam logic [IW-1:0] IDX_WIN_H  = 4'd7;
    localparam logic [IW-1:0] IDX_WIN_VS = 4'd8;
    localparam logic [IW-1:0] IDX_WIN_VE = 4'd9;
    localparam logic [IW-1:0] IDX_BORDER = 4'd10;
    localparam logic [IW-1:0] IDX_UFLOW  = 4'd11;
    localparam logic [IW-1:0] IDX_SKEW   = 4'd12;
    localparam logic [IW-1:0] IDX_POL    = 4'd14;

    localparam int HI_LSB = 16;      // upper half-field position
    localparam int FLAG_BIT = 31;    // enable / recovery flag position

    typedef struct packed {
        logic [HW-1:0] line_len;
        logic [HW-1:0] hs_width;
        logic [HW-1:0] hs_skew;
        logic [HW-1:0] disp_x0;
        logic [HW-1:0] disp_x1;
        logic          win_x_on;
        logic [HW-1:0] win_x0;
        logic [HW-1:0] win_x1;
        logic [FW-1:0] frame_len;
        logic [FW-1:0] vs_width;
        logic [FW-1:0] disp_y0;
        logic [FW-1:0] disp_y1;
        logic          win_y_on;
        logic [FW-1:0] win_y0;
        logic [FW-1:0] win_y1;
        logic [PW-1:0] border_col;
        logic [PW-1:0] uflow_col;
        logic          uflow_hold;
        logic [2:0]    invert;
    } tcfg_t;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic          load,
    output logic          run,
    output tcfg_t         cfg
);
    typedef struct packed {
        logic  run;
        tcfg_t live;
        tcfg_t work;
    } regs_t;

    regs_t rs_d, rs_q;
    logic [IW-1:0] idx;
    logic unused_wbits;

    assign idx = addr[AW-1:2];
    assign unused_wbits = ^{wdata, addr[1:0]};

    always_comb begin
        rs_d = rs_q;
        if (load) begin
            rs_d.work = rs_q.live;
        end
        if (we) begin
            case (idx)
                IDX_RUN: rs_d.run = wdata[0];
                IDX_LINE: begin
                    rs_d.live.line_len = wdata[HI_LSB +: HW];
                    rs_d.live.hs_width = wdata[0 +: HW];
                end
                IDX_FRAME: rs_d.live.frame_len = wdata[0 +: FW];
                IDX_FSYNC: rs_d.live.vs_width = wdata[0 +: FW];
                IDX_DISP_H: begin
                    rs_d.live.disp_x1 = wdata[HI_LSB +: HW];
                    rs_d.live.disp_x0 = wdata[0 +: HW];
                end
                IDX_DISP_VS: rs_d.live.disp_y0 = wdata[0 +: FW];
                IDX_DISP_VE: rs_d.live.disp_y1 = wdata[0 +: FW];
                IDX_WIN_H: begin
                    rs_d.live.win_x_on = wdata[FLAG_BIT];
                    rs_d.live.win_x1   = wdata[HI_LSB +: HW];
                    rs_d.live.win_x0   = wdata[0 +: HW];
                end
                IDX_WIN_VS: begin
                    rs_d.live.win_y_on = wdata[FLAG_BIT];
                    rs_d.live.win_y0   = wdata[0 +: FW];
                end
                IDX_WIN_VE: rs_d.live.win_y1 = wdata[0 +: FW];
                IDX_BORDER: rs_d.live.border_col = wdata[0 +: PW];
                IDX_UFLOW: begin
                    rs_d.live.uflow_hold = wdata[FLAG_BIT];
                    rs_d.live.uflow_col  = wdata[0 +: PW];
                end
                IDX_SKEW: rs_d.live.hs_skew = wdata[0 +: HW];
                IDX_POL: rs_d.live.invert = wdata[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign run = rs_q.run;
    assign cfg = rs_q.work;
endmodule

// File: rtl/ptg_counters.sv
module ptg_counters
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] line_len,
    input  logic [FW-1:0] frame_len,
    output logic [HW-1:0] lpos,
    output logic [FW-1:0] fpos,
    output logic          fwrap
);
    localparam logic [HW:0] ONE_H = {{HW{1'b0}}, 1'b1};
    localparam logic [FW:0] ONE_F = {{FW{1'b0}}, 1'b1};

    typedef struct packed {
        logic [HW-1:0] lpos;
        logic [FW-1:0] fpos;
    } cnt_t;

    cnt_t cn_d, cn_q;
    logic [HW:0] lnext;
    logic [FW:0] fnext;
    logic        lwrap;

    assign lnext = {1'b0, cn_q.lpos} + ONE_H;
    assign fnext = {1'b0, cn_q.fpos} + ONE_F;
    assign lwrap = lnext >= {1'b0, line_len};
    assign fwrap = run && (fnext >= {1'b0, frame_len});

    always_comb begin
        cn_d = cn_q;
        if (!run) begin
            cn_d = '0;
        end else if (fwrap) begin
            cn_d = '0;
        end else begin
            cn_d.fpos = fnext[FW-1:0];
            cn_d.lpos = lwrap ? '0 : lnext[HW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cn_q <= '0;
        end else begin
            cn_q <= cn_d;
        end
    end

    assign lpos = cn_q.lpos;
    assign fpos = cn_q.fpos;
endmodule

// File: rtl/ptg_pixel.sv
module ptg_pixel
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] lpos,
    input  logic [FW-1:0] fpos,
    input  logic          fwrap,
    input  tcfg_t         cfg,
    input  logic          pix_valid,
    input  logic [PW-1:0] pix_data,
    output logic          pix_ready,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [PW-1:0] rgb
);
    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic [PW-1:0] rgb;
        logic          lock;
    } pix_t;

    pix_t px_d, px_q;
    logic [HW:0] hs_end;
    logic hs_raw, vs_raw, in_x, in_y, de_raw, win_x, win_y, active;
    logic unused_cfg;

    assign unused_cfg = ^{cfg.line_len, cfg.frame_len};
    assign hs_end = {1'b0, cfg.hs_skew} + {1'b0, cfg.hs_width};

    always_comb begin
        hs_raw = run && (lpos >= cfg.hs_skew) && ({1'b0, lpos} < hs_end);
        vs_raw = run && (fpos < cfg.vs_width);
        in_x   = (lpos >= cfg.disp_x0) && (lpos <= cfg.disp_x1);
        in_y   = (fpos >= cfg.disp_y0) && (fpos <= cfg.disp_y1);
        de_raw = run && in_x && in_y;
        win_x  = cfg.win_x_on ? ((lpos >= cfg.win_x0) && (lpos <= cfg.win_x1)) : in_x;
        win_y  = cfg.win_y_on ? ((fpos >= cfg.win_y0) && (fpos <= cfg.win_y1)) : in_y;
        active = de_raw && win_x && win_y;
    end

    assign pix_ready = active && !px_q.lock;

    always_comb begin
        px_d    = px_q;
        px_d.hs = hs_raw ^ cfg.invert[0];
        px_d.vs = vs_raw ^ cfg.invert[1];
        px_d.de = de_raw ^ cfg.invert[2];
        if (!de_raw) begin
            px_d.rgb = '0;
        end else if (!active) begin
            px_d.rgb = cfg.border_col;
        end else if (px_q.lock || !pix_valid) begin
            px_d.rgb = cfg.uflow_col;
        end else begin
            px_d.rgb = pix_data;
        end
        if (!run || fwrap) begin
            px_d.lock = 1'b0;
        end else if (active && !px_q.lock && !pix_valid && cfg.uflow_hold) begin
            px_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign hsync = px_q.hs;
    assign vsync = px_q.vs;
    assign de    = px_q.de;
    assign rgb   = px_q.rgb;
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [5:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          pix_valid,
    input  logic [23:0]   pix_data,
    output logic          pix_ready,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic [23:0]   lcd_rgb
);
    logic          run;
    logic          fwrap;
    logic [HW-1:0] lpos;
    logic [FW-1:0] fpos;
    tcfg_t         cfg_work;

    ptg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .load  (!run || fwrap),
        .run   (run),
        .cfg   (cfg_work)
    );

    ptg_counters u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .line_len  (cfg_work.line_len),
        .frame_len (cfg_work.frame_len),
        .lpos      (lpos),
        .fpos      (fpos),
        .fwrap     (fwrap)
    );

    ptg_pixel u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .lpos      (lpos),
        .fpos      (fpos),
        .fwrap     (fwrap),
        .cfg       (cfg_work),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .hsync     (lcd_hsync),
        .vsync     (lcd_vsync),
        .de        (lcd_de),
        .rgb       (lcd_rgb)
    );
endmodule

// File: rtl/ptg_chk.sv
module ptg_chk
    import ptg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          fwrap,
    input logic [HW-1:0] lpos,
    input logic [FW-1:0] fpos,
    input tcfg_t         cfg_work,
    input logic          lcd_hsync,
    input logic          lcd_vsync,
    input logic          pix_ready,
    input logic          pix_valid
);
    // R12
    idle_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (lpos == '0 && fpos == '0));

    // R11
    work_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fwrap) |=> $stable(cfg_work));

    // R2
    line_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lcd_hsync == ($past(cfg_work.invert[0]) ^ ($past(run)
            && ({1'b0, $past(lpos)} >= {1'b0, $past(cfg_work.hs_skew)})
            && ({1'b0, $past(lpos)} < ({1'b0, $past(cfg_work.hs_skew)} + {1'b0, $past(cfg_work.hs_width)})))));

    // R3
    frame_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lcd_vsync == ($past(cfg_work.invert[1]) ^ ($past(run) && ($past(fpos) < $past(cfg_work.vs_width)))));

    // R8
    recovery_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_work.uflow_hold && pix_ready && !pix_valid && !fwrap) |=> !pix_ready);

    // R9
    ready_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> run);
endmodule

bind panel_timing_gen ptg_chk u_ptg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .fwrap     (fwrap),
    .lpos      (lpos),
    .fpos      (fpos),
    .cfg_work  (cfg_work),
    .lcd_hsync (lcd_hsync),
    .lcd_vsync (lcd_vsync),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid)
);

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;
    localparam int BORDER = 32'h00ABCDEF;
    localparam int UFCOL  = 32'h00123456;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready, lcd_hsync, lcd_vsync, lcd_de;
    logic [23:0] lcd_rgb;

    panel_timing_gen u_panel_timing_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .lcd_rgb(lcd_rgb)
    );

    int n_checks = 0;
    int n_fail = 0;
    string ph_req = "R1";
    bit done = 0;

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // ---------------- reference model ----------------
    logic [31:0] live [16];
    logic [31:0] wk [16];
    int  lc = 0, fc = 0;
    bit  lock = 0;
    bit  m_on = 0;
    logic        e_hs = 0, e_vs = 0, e_de = 0, e_rdy = 0;
    logic [23:0] e_rgb = '0;

    function automatic bit is_active(int l, int f);
        int x0, x1, y0, y1;
        bit dx, dy, ax, ay;
        x0 = int'(wk[4][11:0]);  x1 = int'(wk[4][27:16]);
        y0 = int'(wk[5][23:0]);  y1 = int'(wk[6][23:0]);
        dx = (l >= x0) && (l <= x1);
        dy = (f >= y0) && (f <= y1);
        ax = wk[7][31] ? ((l >= int'(wk[7][11:0])) && (l <= int'(wk[7][27:16]))) : dx;
        ay = wk[8][31] ? ((f >= int'(wk[8][23:0])) && (f <= int'(wk[9][23:0]))) : dy;
        return live[0][0] && dx && dy && ax && ay;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin live[i] = '0; wk[i] = '0; end
            lc = 0; fc = 0; lock = 0;
            e_hs = 0; e_vs = 0; e_de = 0; e_rgb = '0; e_rdy = 0;
        end else begin
            bit on, hs, vs, dx, dy, de, act, fw, lw;
            int skew, hw, lp, fp;
            on   = live[0][0];
            lp   = int'(wk[1][27:16]);
            hw   = int'(wk[1][11:0]);
            fp   = int'(wk[2][23:0]);
            skew = int'(wk[12][11:0]);
            hs = on && (lc >= skew) && (lc < skew + hw);
            vs = on && (fc < int'(wk[3][23:0]));
            dx = (lc >= int'(wk[4][11:0])) && (lc <= int'(wk[4][27:16]));
            dy = (fc >= int'(wk[5][23:0])) && (fc <= int'(wk[6][23:0]));
            de = on && dx && dy;
            act = is_active(lc, fc);
            e_hs = hs ^ wk[14][0];
            e_vs = vs ^ wk[14][1];
            e_de = de ^ wk[14][2];
            if (!de)                     e_rgb = '0;
            else if (!act)               e_rgb = wk[10][23:0];
            else if (lock || !pix_valid) e_rgb = wk[11][23:0];
            else                         e_rgb = pix_data;
            fw = on && (fc + 1 >= fp);
            lw = (lc + 1 >= lp);
            if (!on || fw) lock = 0;
            else if (act && !lock && !pix_valid && wk[11][31]) lock = 1;
            if (!on || fw) begin lc = 0; fc = 0; end
            else begin fc = fc + 1; lc = lw ? 0 : lc + 1; end
            if (!on || fw) for (int i = 0; i < 16; i++) wk[i] = live[i];
            if (reg_we) live[reg_addr[5:2]] = reg_wdata;
            e_rdy = is_active(lc, fc) && !lock;
        end
        m_on = 1;
    end

    always @(negedge clk) begin
        if (m_on && !done) begin
            chk({ph_req, "/R2"}, "hsync", {31'd0, lcd_hsync}, {31'd0, e_hs});
            chk({ph_req, "/R3"}, "vsync", {31'd0, lcd_vsync}, {31'd0, e_vs});
            chk({ph_req, "/R4"}, "de", {31'd0, lcd_de}, {31'd0, e_de});
            chk({ph_req, "/R6"}, "rgb", {8'd0, lcd_rgb}, {8'd0, e_rgb});
            chk({ph_req, "/R9"}, "ready", {31'd0, pix_ready}, {31'd0, e_rdy});
        end
    end

    // ---------------- pixel source ----------------
    int  vmode = 0;
    int  cyc = 0;
    bit  hs_pend = 0;
    always @(negedge clk) begin
        if (hs_pend) pix_data = pix_data + 24'd1;
        cyc++;
        case (vmode)
            0: pix_valid = 1'b1;
            1: pix_valid = (cyc % 7) != 3;
            default: pix_valid = (cyc % 3) != 0;
        endcase
        hs_pend = pix_valid && pix_ready;
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic count_win(int n, output int hsn, output int bdn);
        hsn = 0; bdn = 0;
        repeat (n) begin
            @(negedge clk); #1;
            if (pix_valid && pix_ready) hsn++;
            if (lcd_rgb == BORDER[23:0]) bdn++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        done = 1;
        finish_run();
    end

    initial begin
        int h, b;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset hsync", {31'd0, lcd_hsync}, 0);
        chk("R1", "reset vsync", {31'd0, lcd_vsync}, 0);
        chk("R1", "reset de", {31'd0, lcd_de}, 0);
        chk("R1", "reset rgb", {8'd0, lcd_rgb}, 0);
        chk("R1", "reset ready", {31'd0, pix_ready}, 0);
        rst_n = 1'b1;

        // base setup: 10-clock lines, 6-line frame, 5x3 display area
        wr(6'h04, (32'd10 << 16) | 32'd2);
        wr(6'h08, 32'd60);
        wr(6'h0C, 32'd10);
        wr(6'h10, (32'd8 << 16) | 32'd4);
        wr(6'h14, 32'd20);
        wr(6'h18, 32'd49);
        wr(6'h28, BORDER);
        wr(6'h2C, UFCOL);
        repeat (5) @(negedge clk);
        #1;
        chk("R1", "idle before run de", {31'd0, lcd_de}, 0);
        ph_req = "R12";
        wr(6'h00, 32'd1);
        repeat (70) @(negedge clk);
        count_win(60, h, b);
        chk("R9", "pixels taken per frame", h, 15);
        repeat (60) @(negedge clk);

        ph_req = "R7";
        vmode = 1;
        repeat (140) @(negedge clk);
        vmode = 0;

        ph_req = "R11";
        wr(6'h1C, 32'h8000_0000 | (32'd6 << 16) | 32'd5);
        wr(6'h20, 32'h8000_0000 | 32'd30);
        wr(6'h24, 32'd39);
        ph_req = "R5";
        repeat (80) @(negedge clk);
        count_win(60, h, b);
        chk("R5", "pixels taken in sub-window", h, 2);
        chk("R6", "border pixels per frame", b, 13);

        ph_req = "R11";
        wr(6'h1C, 32'd0);
        wr(6'h20, 32'd0);
        ph_req = "R8";
        wr(6'h2C, 32'h8000_0000 | UFCOL);
        vmode = 2;
        repeat (200) @(negedge clk);
        vmode = 1;
        repeat (130) @(negedge clk);
        vmode = 0;
        repeat (70) @(negedge clk);
        count_win(60, h, b);
        chk("R8", "input resumes after lock", h, 15);

        ph_req = "R10";
        wr(6'h38, 32'd7);
        wr(6'h30, 32'd1);
        wr(6'h14, 32'd21);
        wr(6'h18, 32'd50);
        vmode = 1;
        repeat (150) @(negedge clk);

        ph_req = "R12";
        wr(6'h00, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk("R12", "stopped hsync (inverted)", {31'd0, lcd_hsync}, 1);
        chk("R12", "stopped vsync (inverted)", {31'd0, lcd_vsync}, 1);
        chk("R10", "stopped de (inverted)", {31'd0, lcd_de}, 1);
        chk("R12", "stopped ready", {31'd0, pix_ready}, 0);
        chk("R12", "stopped rgb", {8'd0, lcd_rgb}, 0);
        wr(6'h00, 32'd1);
        repeat (130) @(negedge clk);

        done = 1;
        finish_run();
    end
endmodule